// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block is a register-mapped pulse-width modulator with four outputs that run on their own. Each output has a 16-bit cycle length, a 16-bit high-time count, a 6-bit clock divider, a run bit, a level-sense bit and a stored drive-style bit. A channel that is running divides the input clock by its divider value plus one. Each divided tick advances a cycle counter, and the output is asserted for the first high-time ticks of every cycle-length ticks.

Software reprograms a channel in three steps. It clears the run bit, writes the new divider, length, high-time and level-sense values, and then sets the run bit again. The rising edge of the run bit copies the divider, length and high-time into working copies and restarts the counters from zero. Later writes to those three values do not change a running waveform until the next restart. The level-sense bit acts on the output at once. Register access is single-cycle: a write takes effect on the clock edge where it is sampled, and read data appears on the edge after the read strobe and holds until the next read.

Top module: `pwm_bank_top`

## Requirements
- R1: After reset, every register reads 0x00000000. Every output is high, because a level-sense bit of 0 selects inverted output with an inactive level of high.
- R2: The control word is at byte address 0x00. Bits 3:0 are the run bits of channels 3..0, bits 11:8 are the level-sense bits, and bits 18:15 are the drive-style bits. All other bits are ignored on write and read as 0.
- R3: Channel c has its cycle length at address 0x04+8c and its high-time at address 0x08+8c. Only bits 15:0 are stored, and bits 31:16 read as 0.
- R4: The divider word is at address 0x24. Channel c's 6-bit divider occupies bits (3-c)*6+5 : (3-c)*6, so channel 0 sits at 23:18 and channel 3 at 5:0. Bits 31:24 read as 0.
- R5: A read of any address that is not mapped returns 0. A write to such an address changes nothing.
- R6: While a channel's run bit is 0, its output sits at the inactive level on the cycle after the bit is seen low. The inactive level is low when the level-sense bit is 1 and high when it is 0.
- R7: The edge that sets a run bit loads the working copies. From the next edge on, with divider P, length N and high-time D, the output is active during cycles t where floor(t/(P+1)) mod N < D, counting t = 0 from that next edge.
- R8: A high-time of 0 keeps the output inactive for the whole cycle. A high-time equal to or greater than the length keeps it active for the whole cycle.
- R9: Writes to a running channel's length, high-time or divider do not change its waveform until its run bit is cleared and set again.
- R10: A level-sense bit of 1 gives an active-high output and 0 gives an active-low output. A change of the bit affects the output from the edge that writes it, and the counters are not restarted.
- R11: Each channel runs independently. A write to another channel's fields, or a control write that leaves this channel's run bit set, does not disturb this channel's counters.
- R12: The drive-style bits are stored and read back only, and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered and held until the next read |
| pwm_out | output | 4 | Modulated outputs, bit c is channel c |

## Verification
The assertions check four things on every cycle for every channel. A channel whose run bit is low shows its inactive level. A channel shows the level implied by its high-time on the first cycle after a restart. Reserved control bits, the upper halves of the count registers and unmapped addresses always read as zero. Only the bench scenarios can show the rest: the full waveform shape under each divider, the capture of the working copies on restart, the immunity of a running channel to reprogramming and to its neighbours' writes, and the exact packing of the divider fields. The bench checks these by comparing every output on every cycle against a model of the waveform equation.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int NUM_CH   = 4;
    localparam int CNT_W    = 16;
    localparam int PSC_W    = 6;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;

    localparam int CTRL_ADDR  = 'h00;
    localparam int LEN_BASE   = 'h04;
    localparam int HIGH_BASE  = 'h08;
    localparam int CH_STRIDE  = 8;
    localparam int DIV_ADDR   = 'h24;
    localparam int SENSE_LSB  = 8;
    localparam int STYLE_LSB  = 15;

    typedef struct packed {
        logic [PSC_W-1:0] div;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] high;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_bank_pkg::*;
#(
    parameter int W = PSC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run || restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == limit) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run_bit,
    input  logic    sense,
    input  ch_cfg_t cfg,
    output logic    wave
);
    typedef struct packed {
        logic             running;
        logic             run_prev;
        logic [CNT_W-1:0] pos;
        ch_cfg_t          work;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      restart;
    logic      tick;
    logic      last_pos;
    logic      active;

    assign restart = run_bit && !st_q.run_prev;

    pwm_tick_gen #(.W(PSC_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.running),
        .restart (restart),
        .limit   (st_q.work.div),
        .tick    (tick)
    );

    always_comb begin
        st_d          = st_q;
        st_d.run_prev = run_bit;
        st_d.running  = run_bit;
        last_pos      = ({1'b0, st_q.pos} + 1'b1) >= {1'b0, st_q.work.len};
        if (restart) begin
            st_d.work = cfg;
            st_d.pos  = '0;
        end else if (!st_q.running) begin
            st_d.pos = '0;
        end else if (tick) begin
            st_d.pos = last_pos ? '0 : st_q.pos + 1'b1;
        end
        active = st_q.running && (st_q.pos < st_q.work.high);
        wave   = active ~^ sense;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_bank_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [NUM_CH-1:0]            run_bits,
    output logic [NUM_CH-1:0]            sense_bits,
    output ch_cfg_t [NUM_CH-1:0]         cfg
);
    typedef struct packed {
        logic [NUM_CH-1:0]             run;
        logic [NUM_CH-1:0]             sense;
        logic [NUM_CH-1:0]             style;
        logic [NUM_CH-1:0][CNT_W-1:0]  len;
        logic [NUM_CH-1:0][CNT_W-1:0]  high;
        logic [NUM_CH-1:0][PSC_W-1:0]  div;
        logic [DATA_W-1:0]             rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;

    function automatic logic [ADDR_W-1:0] len_addr(input int c);
        return ADDR_W'(LEN_BASE + CH_STRIDE * c);
    endfunction

    function automatic logic [ADDR_W-1:0] high_addr(input int c);
        return ADDR_W'(HIGH_BASE + CH_STRIDE * c);
    endfunction

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
                st_d.run   = bus_wdata[NUM_CH-1:0];
                st_d.sense = bus_wdata[SENSE_LSB +: NUM_CH];
                st_d.style = bus_wdata[STYLE_LSB +: NUM_CH];
            end
            if (bus_addr == ADDR_W'(DIV_ADDR)) begin
                for (int c = 0; c < NUM_CH; c++)
                    st_d.div[c] = bus_wdata[(NUM_CH-1-c)*PSC_W +: PSC_W];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == len_addr(c))  st_d.len[c]  = bus_wdata[CNT_W-1:0];
                if (bus_addr == high_addr(c)) st_d.high[c] = bus_wdata[CNT_W-1:0];
            end
        end
        if (bus_rd) begin
            st_d.rdata = '0;
            if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
                st_d.rdata[NUM_CH-1:0]             = st_q.run;
                st_d.rdata[SENSE_LSB +: NUM_CH]    = st_q.sense;
                st_d.rdata[STYLE_LSB +: NUM_CH]    = st_q.style;
            end
            if (bus_addr == ADDR_W'(DIV_ADDR)) begin
                for (int c = 0; c < NUM_CH; c++)
                    st_d.rdata[(NUM_CH-1-c)*PSC_W +: PSC_W] = st_q.div[c];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == len_addr(c))  st_d.rdata[CNT_W-1:0] = st_q.len[c];
                if (bus_addr == high_addr(c)) st_d.rdata[CNT_W-1:0] = st_q.high[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign run_bits   = st_q.run;
    assign sense_bits = st_q.sense;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            cfg[c].div  = st_q.div[c];
            cfg[c].len  = st_q.len[c];
            cfg[c].high = st_q.high[c];
        end
    end
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [3:0]        pwm_out
);
    logic [NUM_CH-1:0]        run_w;
    logic [NUM_CH-1:0]        sense_w;
    ch_cfg_t [NUM_CH-1:0]     cfg_w;
    logic [NUM_CH*CNT_W-1:0]  high_w;

    pwm_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .run_bits   (run_w),
        .sense_bits (sense_w),
        .cfg        (cfg_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign high_w[c*CNT_W +: CNT_W] = cfg_w[c].high;
        pwm_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_bit (run_w[c]),
            .sense   (sense_w[c]),
            .cfg     (cfg_w[c]),
            .wave    (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_rd,
    input logic [7:0]                bus_addr,
    input logic [31:0]               bus_rdata,
    input logic [NUM_CH-1:0]         pwm_out,
    input logic [NUM_CH-1:0]         run_vec,
    input logic [NUM_CH-1:0]         sense_vec,
    input logic [NUM_CH*CNT_W-1:0]   high_vec
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !run_vec[c] |=> (pwm_out[c] == !sense_vec[c]));

        a_r7_first_level: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_vec[c]) |=>
                (pwm_out[c] == (($past(high_vec[c*CNT_W +: CNT_W]) != '0) ~^ sense_vec[c])));
    end

    a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h00) |=>
            (bus_rdata[7:4] == '0 && bus_rdata[14:12] == '0 && bus_rdata[31:19] == '0));

    a_r3_count_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= 8'h04 && bus_addr <= 8'h20) |=> (bus_rdata[31:16] == '0));

    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > 8'h24) |=> (bus_rdata == '0));

    a_r4_div_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h24) |=> (bus_rdata[31:24] == '0));
endmodule

bind pwm_bank_top pwm_bank_chk #(.NUM_CH(4), .CNT_W(16)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .run_vec   (run_w),
    .sense_vec (sense_w),
    .high_vec  (high_w)
);

// File: tb/tb_pwm_bank_top.sv
`timescale 1ns/1ps
module tb_pwm_bank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    always #2 clk = ~clk;

    pwm_bank_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    localparam longint NEVER = 64'h7fff_ffff_ffff;
    logic [31:0] m_ctrl = '0;
    logic [15:0] m_len[4], m_high[4], w_len[4], w_high[4];
    logic [5:0]  m_div[4], w_div[4];
    longint      t_on[4], t_off[4];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] div_word();
        logic [31:0] w = '0;
        for (int c = 0; c < 4; c++) w[(3-c)*6 +: 6] = m_div[c];
        return w;
    endfunction

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] nc;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h00) begin
            nc = d & 32'h0007_8F0F;
            for (int c = 0; c < 4; c++) begin
                if (nc[c] && !m_ctrl[c]) begin
                    w_len[c] = m_len[c]; w_high[c] = m_high[c]; w_div[c] = m_div[c];
                    t_on[c] = cyc + 1; t_off[c] = NEVER;
                end else if (!nc[c] && m_ctrl[c]) begin
                    t_off[c] = cyc + 1;
                end
            end
            m_ctrl = nc;
        end
        if (a == 8'h24) for (int c = 0; c < 4; c++) m_div[c] = d[(3-c)*6 +: 6];
        for (int c = 0; c < 4; c++) begin
            if (a == 8'(4 + 8*c)) m_len[c]  = d[15:0];
            if (a == 8'(8 + 8*c)) m_high[c] = d[15:0];
        end
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic exp_out(input int c);
        logic act = 1'b0;
        longint t, k;
        if (cyc >= t_on[c] && cyc < t_off[c]) begin
            t = cyc - t_on[c];
            k = (t / (longint'(w_div[c]) + 1)) % longint'(w_len[c]);
            act = (k < longint'(w_high[c]));
        end
        return act ~^ m_ctrl[8+c];
    endfunction

    task automatic watch(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) chk(req, 32'(pwm_out[c]), 32'(exp_out(c)));
        end
    endtask

    task automatic set_ch(input int c, input int dv, input int ln, input int hi);
        m_div[c] = 6'(dv);
        bw(8'h24, div_word());
        bw(8'(4 + 8*c), 32'(ln));
        bw(8'(8 + 8*c), 32'(hi));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin
            m_len[c] = '0; m_high[c] = '0; m_div[c] = '0;
            w_len[c] = 16'd1; w_high[c] = '0; w_div[c] = '0;
            t_on[c] = NEVER; t_off[c] = NEVER;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a <= 'h24; a += 4) begin
            br(8'(a), rd); chk("R1", rd, 32'h0);
        end
        chk("R1", 32'(pwm_out), 32'hF);

        // R2 control layout and reserved bits
        bw(8'h00, 32'hFFFF_FFFF);
        br(8'h00, rd); chk("R2", rd, 32'h0007_8F0F);
        bw(8'h00, 32'h0);
        br(8'h00, rd); chk("R2", rd, 32'h0);

        // R12 drive-style bits only stored
        bw(8'h00, 32'h0007_8000);
        watch(6, "R12");
        br(8'h00, rd); chk("R12", rd, 32'h0007_8000);

        // R3 count registers
        bw(8'h04, 32'hABCD_1234);
        br(8'h04, rd); chk("R3", rd, 32'h0000_1234);
        bw(8'h20, 32'hFFFF_5678);
        br(8'h20, rd); chk("R3", rd, 32'h0000_5678);
        br(8'h08, rd); chk("R3", rd, 32'h0);

        // R4 divider packing
        bw(8'h24, 32'hFFFF_FFFF);
        br(8'h24, rd); chk("R4", rd, 32'h00FF_FFFF);
        m_div[0] = 6'd1; m_div[1] = 6'd2; m_div[2] = 6'd3; m_div[3] = 6'd4;
        bw(8'h24, div_word());
        br(8'h24, rd); chk("R4", rd, 32'h0004_20C4);

        // R5 unmapped addresses
        bw(8'h30, 32'hFFFF_FFFF);
        br(8'h30, rd); chk("R5", rd, 32'h0);
        br(8'hFC, rd); chk("R5", rd, 32'h0);
        br(8'h02, rd); chk("R5", rd, 32'h0);

        // R6 idle level follows level-sense
        bw(8'h00, 32'h0000_0F00);
        watch(4, "R6");
        chk("R6", 32'(pwm_out), 32'h0);

        // R7 / R8 directed waveforms
        set_ch(0, 1, 4, 1);
        set_ch(1, 0, 5, 0);
        set_ch(2, 0, 4, 4);
        set_ch(3, 2, 6, 9);
        bw(8'h00, 32'h0000_0F0F);
        watch(80, "R7");
        set_ch(3, 0, 5, 2);
        bw(8'h00, 32'h0000_0F07);
        bw(8'h00, 32'h0000_0F0F);
        watch(40, "R8");

        // R9 reprogramming while running has no effect
        set_ch(0, 3, 9, 5);
        set_ch(2, 2, 3, 1);
        watch(60, "R9");
        bw(8'h00, 32'h0000_0F0A);
        bw(8'h00, 32'h0000_0F0F);
        watch(60, "R9");

        // R10 level-sense change while running
        bw(8'h00, 32'h0000_050F);
        watch(30, "R10");
        bw(8'h00, 32'h0000_0A0F);
        watch(30, "R10");

        // R11 random reprogramming with neighbour traffic
        for (int it = 0; it < 30; it++) begin
            int c, o;
            logic [31:0] nc;
            c = int'($urandom_range(3, 0));
            nc = m_ctrl & ~(32'h1 << c);
            bw(8'h00, nc);
            begin
                int ln = int'($urandom_range(30, 2));
                set_ch(c, int'($urandom_range(3, 0)), ln, int'($urandom_range(ln + 2, 0)));
            end
            o = (c + 1 + int'($urandom_range(2, 0))) % 4;
            bw(8'(8 + 8*o), 32'($urandom_range(40, 0)));
            nc = m_ctrl | (32'h1 << c);
            nc[8+c] = 1'($urandom_range(1, 0));
            nc[15+c] = 1'($urandom_range(1, 0));
            bw(8'h00, nc);
            watch(100, "R11");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule